// File: doc/BRIEF.md
# Interval Counter Channel

This block is a single binary down-counting timer channel for a larger chip. It counts pulses of a timer clock enable rather than the system clock. A load strobe brings in a new terminal value together with an operating mode, and the channel then shows two things at its pins: the visible count and one waveform output.

Six waveform behaviours are available: an interrupt on terminal count, a gate-triggered one-shot, a periodic rate pulse, a square wave, and two single-tick strobes. Both strobes fire once on the terminal tick. In one of them software starts the run by loading a value, and in the other a rising edge on the gate starts it. The gate input either holds counting or retriggers it, depending on the mode. A loaded value of zero stands for the full range, 2^CNT_W ticks.

Top module: `ivt_channel`

## Requirements
- R1: After synchronous reset the channel runs the square-wave mode (code 3) with a terminal value of 2^CNT_W. Out of reset, wave_out is 1 and count_out is 0. One counted tick later count_out is 2^CNT_W-2.
- R2: A load with load_val equal to 0 sets a terminal value N of 2^CNT_W.
- R3: On a clock edge with load_stb high, the channel takes in mode_sel and load_val and sets the elapsed tick count d to 0. A tick_en that is high on that same edge is not counted.
- R4: In mode 0, wave_out is 0 while d < N and 1 once d >= N. It stays 1 until the next load.
- R5: In mode 1, wave_out is 0 while d < N and 1 once d >= N. A gate rising edge sets d back to 0, so the output drops again.
- R6: In mode 2, wave_out is 1 for exactly the ticks where d is a nonzero multiple of N, and 0 otherwise. count_out is (N - d mod N) mod 2^CNT_W.
- R7: In mode 3, wave_out is 1 while (d mod N) < (N+1)/2 and 0 for the rest of each period. count_out is (N - (2d mod N)) mod 2^CNT_W, so it falls by 2 per tick.
- R8: In modes 4 and 5, wave_out is 1 only while d equals N.
- R9: In modes 0, 1, 4 and 5, count_out is (N - d) mod 2^CNT_W. It keeps wrapping after the terminal value.
- R10: In modes 1, 2, 3 and 5, a rising gate edge (gate 1 now, 0 at the previous clock edge) sets d to 0. It takes precedence over a tick on the same edge. In modes 0 and 4, a gate edge does not restart the count.
- R11: In modes 0, 2, 3 and 4, a tick_en seen while gate is 0 is not counted. In modes 1 and 5, ticks are counted whatever the gate level.
- R12: The mode_sel codes are 0 to 5 as listed above. Code 6 behaves as mode 2 and code 7 behaves as mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer clock enable; one counted tick per high cycle |
| load_stb | input | 1 | Load new mode and terminal value |
| load_val | input | CNT_W (16) | Terminal value, 0 means 2^CNT_W |
| mode_sel | input | 3 | Mode code captured on load |
| gate | input | 1 | Gate level: holds counting or retriggers, depending on the mode |
| count_out | output | CNT_W (16) | Visible count |
| wave_out | output | 1 | Waveform output |

## Verification
Every input, whether a load, a tick or a gate edge, is taken in on one clock edge. Both outputs are decoded combinationally from the registers that edge writes, so each result is due in the same cycle, immediately after that edge. The bench drives inputs on the falling edge and lets one rising edge go by. It then checks count_out and wave_out at the next falling edge against a model that tracks only the elapsed ticks since the last load or restart. It runs this check after every single step, and it sweeps all eight mode codes over several small terminal values with the gate held high and with the gate and tick following a pseudo-random pattern.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        M_TC_IRQ   = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } ivt_mode_e;

    typedef struct packed {
        ivt_mode_e mode;
        logic      periodic;   // phase wraps at the terminal value
        logic      retrig;     // gate rising edge restarts counting
        logic      gated;      // gate low suspends counting
    } mode_info_t;

    // Codes 6 and 7 fold onto the rate and square modes.
    function automatic ivt_mode_e fold_mode(input logic [2:0] raw);
        case (raw)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return ivt_mode_e'(raw);
        endcase
    endfunction

    function automatic mode_info_t decode_mode(input logic [2:0] raw);
        mode_info_t mi;
        mi.mode     = fold_mode(raw);
        mi.periodic = (mi.mode == M_RATE) || (mi.mode == M_SQUARE);
        mi.retrig   = (mi.mode == M_ONESHOT) || (mi.mode == M_RATE) ||
                      (mi.mode == M_SQUARE)  || (mi.mode == M_HW_STROBE);
        mi.gated    = (mi.mode == M_TC_IRQ) || (mi.mode == M_RATE) ||
                      (mi.mode == M_SQUARE) || (mi.mode == M_SW_STROBE);
        return mi;
    endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic gate_rise
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate;
    end

    assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/ivt_count_core.sv
module ivt_count_core
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       mode_sel,
    input  logic             gate,
    input  logic             gate_rise,
    output mode_info_t       info_q,
    output logic [CNT_W:0]   term_q,
    output logic [CNT_W:0]   phase_q,
    output logic [CNT_W-1:0] elapsed_q,
    output logic             lapped_q
);
    localparam int TW = CNT_W + 1;
    localparam logic [TW-1:0] FULL_TERM = {1'b1, {CNT_W{1'b0}}};

    logic counting;
    logic at_wrap;

    assign counting = tick_en && (gate || !info_q.gated);
    assign at_wrap  = (phase_q == term_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q    <= decode_mode(3'd3);
            term_q    <= FULL_TERM;
            phase_q   <= '0;
            elapsed_q <= '0;
            lapped_q  <= 1'b0;
        end else if (load_stb) begin
            info_q    <= decode_mode(mode_sel);
            term_q    <= (load_val == '0) ? FULL_TERM : {1'b0, load_val};
            phase_q   <= '0;
            elapsed_q <= '0;
            lapped_q  <= 1'b0;
        end else if (gate_rise && info_q.retrig) begin
            phase_q   <= '0;
            elapsed_q <= '0;
            lapped_q  <= 1'b0;
        end else if (counting) begin
            elapsed_q <= elapsed_q + 1'b1;
            if (info_q.periodic) begin
                if (at_wrap) begin
                    phase_q  <= '0;
                    lapped_q <= 1'b1;
                end else begin
                    phase_q  <= phase_q + 1'b1;
                end
            end else if (phase_q <= term_q) begin
                // one-shot phase saturates at term+1
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // R2
    a_r2_zero_load: assert property (@(posedge clk) disable iff (rst)
        load_stb && (load_val == '0) |=> term_q == FULL_TERM);

    // R3
    a_r3_load_clears: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (phase_q == '0) && (elapsed_q == '0) && !lapped_q);

    // R10
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        gate_rise && info_q.retrig && !load_stb |=> (phase_q == '0) && (elapsed_q == '0));

    // R11
    a_r11_hold_gate_low: assert property (@(posedge clk) disable iff (rst)
        !load_stb && !gate_rise && info_q.gated && !gate |=> $stable(phase_q) && $stable(elapsed_q));

    // R7: periodic phase never reaches the terminal value
    a_r7_phase_range: assert property (@(posedge clk) disable iff (rst)
        info_q.periodic |-> phase_q < term_q);
endmodule

// File: rtl/ivt_wave_dec.sv
module ivt_wave_dec
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  mode_info_t       info,
    input  logic [CNT_W:0]   term,
    input  logic [CNT_W:0]   phase,
    input  logic [CNT_W-1:0] elapsed,
    input  logic             lapped,
    output logic             wave,
    output logic [CNT_W-1:0] count
);
    localparam int TW = CNT_W + 1;

    logic [TW-1:0] half;
    logic [TW:0]   dbl;
    logic [TW:0]   dbl_mod;
    logic [TW-1:0] sq_left;
    logic [TW-1:0] rate_left;

    assign half      = (term + 1'b1) >> 1;
    assign dbl       = {phase, 1'b0};
    assign dbl_mod   = (dbl >= {1'b0, term}) ? (dbl - {1'b0, term}) : dbl;
    assign sq_left   = term - dbl_mod[TW-1:0];
    assign rate_left = term - phase;

    always_comb begin
        case (info.mode)
            M_TC_IRQ, M_ONESHOT: begin
                wave  = (phase >= term);
                count = term[CNT_W-1:0] - elapsed;
            end
            M_RATE: begin
                wave  = lapped && (phase == '0);
                count = rate_left[CNT_W-1:0];
            end
            M_SQUARE: begin
                wave  = (phase < half);
                count = sq_left[CNT_W-1:0];
            end
            default: begin
                wave  = (phase == term);
                count = term[CNT_W-1:0] - elapsed;
            end
        endcase
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       mode_sel,
    input  logic             gate,
    output logic [CNT_W-1:0] count_out,
    output logic             wave_out
);
    mode_info_t       info_q;
    logic [CNT_W:0]   term_q;
    logic [CNT_W:0]   phase_q;
    logic [CNT_W-1:0] elapsed_q;
    logic             lapped_q;
    logic             gate_rise;

    ivt_gate_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .gate      (gate),
        .gate_rise (gate_rise)
    );

    ivt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .mode_sel  (mode_sel),
        .gate      (gate),
        .gate_rise (gate_rise),
        .info_q    (info_q),
        .term_q    (term_q),
        .phase_q   (phase_q),
        .elapsed_q (elapsed_q),
        .lapped_q  (lapped_q)
    );

    ivt_wave_dec #(.CNT_W(CNT_W)) u_dec (
        .info    (info_q),
        .term    (term_q),
        .phase   (phase_q),
        .elapsed (elapsed_q),
        .lapped  (lapped_q),
        .wave    (wave_out),
        .count   (count_out)
    );

    // R4: mode 0 output is sticky until a new load
    a_r4_sticky_high: assert property (@(posedge clk) disable iff (rst)
        (info_q.mode == M_TC_IRQ) && wave_out && !load_stb |=> wave_out);

    // R8: strobe lasts a single counted tick
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        wave_out && !load_stb &&
        (((info_q.mode == M_SW_STROBE) && gate && tick_en) ||
         ((info_q.mode == M_HW_STROBE) && (tick_en || gate_rise)))
        |=> !wave_out);

    // R6: rate pulse is one tick wide
    a_r6_rate_pulse: assert property (@(posedge clk) disable iff (rst)
        (info_q.mode == M_RATE) && wave_out && !load_stb && tick_en && gate && (term_q > 1)
        |=> !wave_out);
endmodule

// File: tb/ivt_channel_tb.sv
`timescale 1ns/1ps
module ivt_channel_tb;
    localparam int W = 16;
    localparam int FULL = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_en = 1'b0;
    logic         load_stb = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [2:0]   mode_sel = '0;
    logic         gate = 1'b1;
    logic [W-1:0] count_out;
    logic         wave_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int m_mode, m_n, m_d, m_gprev;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    ivt_channel #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .load_stb(load_stb),
        .load_val(load_val), .mode_sel(mode_sel), .gate(gate),
        .count_out(count_out), .wave_out(wave_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int fold(input int raw);
        if (raw == 6) return 2;
        if (raw == 7) return 3;
        return raw;
    endfunction

    function automatic int exp_wave(input int m, input int n, input int d);
        case (m)
            0, 1:    return (d >= n) ? 1 : 0;
            2:       return (d != 0 && (d % n) == 0) ? 1 : 0;
            3:       return ((d % n) < (n + 1) / 2) ? 1 : 0;
            default: return (d == n) ? 1 : 0;
        endcase
    endfunction

    function automatic int exp_count(input int m, input int n, input int d);
        case (m)
            2:       return (n - (d % n)) & 16'hFFFF;
            3:       return (n - ((2 * d) % n)) & 16'hFFFF;
            default: return (n - d) & 16'hFFFF;
        endcase
    endfunction

    task automatic check(input string tag);
        int ew, ec;
        ew = exp_wave(m_mode, m_n, m_d);
        ec = exp_count(m_mode, m_n, m_d);
        total++;
        if (wave_out !== ew[0] || count_out !== ec[W-1:0]) begin
            bad++;
            $display("FAIL %s mode=%0d n=%0d d=%0d: wave=%0b count=%0d expected wave=%0d count=%0d",
                     tag, m_mode, m_n, m_d, wave_out, count_out, ew, ec);
        end
    endtask

    // Drive at falling edge, take one rising edge, return at the next falling edge.
    task automatic step(input logic t, input logic g);
        tick_en = t;
        gate = g;
        @(posedge clk);
        if ((m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5) && g && !m_gprev)
            m_d = 0;
        else if (t && (g || m_mode == 1 || m_mode == 5))
            m_d++;
        m_gprev = g;
        @(negedge clk);
    endtask

    task automatic do_load(input int raw, input int val, input logic t, input logic g);
        load_stb = 1'b1;
        mode_sel = raw[2:0];
        load_val = val[W-1:0];
        tick_en = t;
        gate = g;
        @(posedge clk);
        m_mode = fold(raw);
        m_n = (val == 0) ? FULL : val;
        m_d = 0;
        m_gprev = g;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    function automatic string mode_tag(input int raw);
        case (raw)
            0: return "R4/R9";
            1: return "R5/R9";
            2: return "R6";
            3: return "R7";
            4, 5: return "R8/R9";
            default: return "R12";
        endcase
    endfunction

    initial begin
        int sizes [6] = '{1, 2, 3, 4, 5, 7};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_mode = 3; m_n = FULL; m_d = 0; m_gprev = 0;
        check("R1 reset");
        step(1'b0, 1'b1);
        check("R1 idle");
        step(1'b1, 1'b1);
        check("R1 first tick");

        // Sweep every mode code with gate high
        for (int raw = 0; raw < 8; raw++) begin
            for (int si = 0; si < 6; si++) begin
                do_load(raw, sizes[si], 1'b1, 1'b1);
                check("R3 load absorbs tick");
                for (int k = 0; k < 2 * sizes[si] + 5; k++) begin
                    step(1'b1, 1'b1);
                    check(mode_tag(raw));
                end
            end
        end

        // Sweep with pseudo-random gate and tick patterns
        for (int raw = 0; raw < 8; raw++) begin
            for (int si = 0; si < 6; si++) begin
                do_load(raw, sizes[si], 1'b0, 1'b1);
                for (int k = 0; k < 3 * sizes[si] + 8; k++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    step(lfsr[1] | lfsr[5], lfsr[0] | lfsr[3]);
                    check("R10/R11 random gate");
                end
            end
        end

        // R10: rate mode restarts on gate rise
        do_load(2, 3, 1'b0, 1'b1);
        step(1'b1, 1'b1); step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        check("R10 rate restart");
        if (count_out !== 16'd3) begin bad++; $display("FAIL R10 count=%0d expected 3", count_out); end
        total++;

        // R10: mode 0 does not restart on gate rise
        do_load(0, 5, 1'b0, 1'b1);
        step(1'b1, 1'b1); step(1'b1, 1'b1);
        step(1'b0, 1'b0); step(1'b0, 1'b1);
        total++;
        if (count_out !== 16'd3) begin bad++; $display("FAIL R10 mode0 count=%0d expected 3", count_out); end

        // R11: mode 1 counts with gate low
        do_load(1, 4, 1'b0, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        check("R11 mode1 gate low");
        total++;
        if (count_out !== 16'd2) begin bad++; $display("FAIL R11 count=%0d expected 2", count_out); end

        // R2: zero load in mode 4 means full range
        do_load(4, 0, 1'b0, 1'b1);
        check("R2 zero load");
        step(1'b1, 1'b1);
        check("R2 first tick");
        for (int k = 0; k < FULL - 2; k++) step(1'b1, 1'b1);
        check("R2 before terminal");
        step(1'b1, 1'b1);
        check("R2 terminal strobe");
        step(1'b1, 1'b1);
        check("R2 after terminal");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule